// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block sits on the bus side of an 8-bit parallel NOR flash device model. The host drives an asynchronous-style bus made of active-low chip enable, write enable and output enable, an address and a data byte. Every bus control line, the low address bits and the data byte pass through a multi-flop synchroniser into the block's clock domain. A command write is committed on the synchronised rising edge of write enable while chip enable is low. The command decoder is a state machine. It walks through unlock prefixes and command bytes and decides what a read cycle returns: array data from the storage model, identification bytes, or the status byte of the embedded erase sequencer.

The decoder states are READ (array reads), UNLK1 (first unlock byte seen), UNLK2 (both unlock bytes seen), IDENT (identification reads), ERS_SETUP (erase setup byte seen), ERS_UNLK1 and ERS_UNLK2 (second unlock pair seen), and ERASE (erase in progress or failed). The transitions are as follows. A matching write advances one step. A mismatching write drops back to READ. In IDENT, the first unlock byte opens a new sequence. ERASE returns to READ when the sequencer reports completion, or when a reset byte arrives while the sequencer is in its failed state. The sequencer states are IDLE, RUN and FAIL. RUN ends in IDLE when the storage side reports completion. It ends in FAIL when a cycle budget runs out first. FAIL ends in IDLE on an abort.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, the block is in array read mode, a read returns `array_rdata`, and `erase_start` is low.
- R2: In array read mode, `bus_dout` equals `array_rdata` while `bus_ce_n` and `bus_oe_n` are both low. At all other times `bus_dout` is 00H.
- R3: The writes AAH to address 555H, 55H to 2AAH and 90H to 555H enter identification mode. Addresses compare on bits 10:0. In this mode a read with address bits 1:0 = 00 returns C2H.
- R4: In identification mode a read with address bits 1:0 = 01 returns B0H when `BOOT_TOP` is 1 and 34H when it is 0. A read with bits 1:0 = 11 returns 00H.
- R5: In identification mode a read with address bits 1:0 = 10 returns 01H when `sect_prot` is high and 00H when it is low.
- R6: A write of F0H returns identification mode to array read mode. The block stays in array read mode until a complete new sequence is written.
- R7: A write that does not match the next expected step returns the decoder to READ, so a sequence broken at any step has no effect.
- R8: The six writes AAH@555H, 55H@2AAH, 80H@555H, AAH@555H, 55H@2AAH, 10H@555H produce exactly one single-cycle `erase_start` pulse, and the sequencer then enters RUN.
- R9: While an erase runs, reads return the status byte. In that byte bit 7 is 0 and bit 5 is 0, and bit 6 inverts on each read cycle. Writes, including F0H, are ignored.
- R10: If `erase_done` is high at any clock edge from the second edge after `erase_start` up to the edge that ends the ERASE_TIMEOUT-cycle budget, the erase completes and reads return array data. If completion and budget expiry fall on the same edge, completion wins.
- R11: If no completion arrives within the budget, the erase fails. Reads then return status with bit 5 = 1 and bit 7 = 0, a later `erase_done` is ignored, and only F0H returns the block to array read mode.
- R12: A write pulse while `bus_ce_n` is high commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ce_n | input | 1 | Bus chip enable, active low |
| bus_we_n | input | 1 | Bus write enable, active low; command taken on its rising edge |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_din | input | 8 | Bus write data |
| bus_dout | output | 8 | Bus read data |
| array_addr | output | ADDR_W | Read address passed to the storage model |
| array_rdata | input | 8 | Storage data at `array_addr` |
| sect_prot | input | 1 | Protection flag of the sector at `array_addr` |
| erase_start | output | 1 | One-cycle chip erase request to the storage side |
| erase_done | input | 1 | Completion indication from the storage side |

## Verification
Two things can land on the same clock edge: the storage side's completion indication and the expiry of the sequencer's cycle budget. The bench times `erase_done` from the observed `erase_start` pulse, so that it is sampled exactly at the last edge of the budget and, in another run, one edge later. A read afterwards must return array data in the first case and failure status with bit 5 set in the second. In the second case, a reset byte must then be the only way back to array reads.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    typedef enum logic [2:0] {
        DS_READ,
        DS_UNLK1,
        DS_UNLK2,
        DS_IDENT,
        DS_ERS_SETUP,
        DS_ERS_UNLK1,
        DS_ERS_UNLK2,
        DS_ERASE
    } dec_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_IDENT,
        RD_STATUS
    } rd_mode_t;

    localparam int CMD_ADDR_W = 11;

    localparam logic [CMD_ADDR_W-1:0] ADDR_KEY_A = 11'h555;
    localparam logic [CMD_ADDR_W-1:0] ADDR_KEY_B = 11'h2AA;

    localparam logic [7:0] BYTE_KEY_A      = 8'hAA;
    localparam logic [7:0] BYTE_KEY_B      = 8'h55;
    localparam logic [7:0] BYTE_IDENT      = 8'h90;
    localparam logic [7:0] BYTE_ERS_SETUP  = 8'h80;
    localparam logic [7:0] BYTE_CHIP_ERASE = 8'h10;
    localparam logic [7:0] BYTE_RESET      = 8'hF0;

    localparam logic [7:0] CODE_MAKER      = 8'hC2;
    localparam logic [7:0] CODE_DEV_TOP    = 8'hB0;
    localparam logic [7:0] CODE_DEV_BOTTOM = 8'h34;

endpackage

// File: rtl/fcmd_bus_sync.sv
module fcmd_bus_sync #(
    parameter int STAGES = 2,
    parameter int AW     = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          rd_start
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] ce_sh;
    logic [STAGES-1:0] we_sh;
    logic [STAGES-1:0] oe_sh;
    logic              we_prev;
    logic              oe_prev;
    logic [AW-1:0]     a_sh [STAGES];
    logic [7:0]        d_sh [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_sh   <= '1;
            we_sh   <= '1;
            oe_sh   <= '1;
            we_prev <= 1'b1;
            oe_prev <= 1'b1;
            for (int i = 0; i < STAGES; i++) begin
                a_sh[i] <= '0;
                d_sh[i] <= '0;
            end
        end else begin
            ce_sh   <= {ce_sh[STAGES-2:0], ce_n};
            we_sh   <= {we_sh[STAGES-2:0], we_n};
            oe_sh   <= {oe_sh[STAGES-2:0], oe_n};
            we_prev <= we_sh[LAST];
            oe_prev <= oe_sh[LAST];
            a_sh[0] <= addr;
            d_sh[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                a_sh[i] <= a_sh[i-1];
                d_sh[i] <= d_sh[i-1];
            end
        end
    end

    // write committed on the synchronised rising edge of write enable
    assign wr_stb   = we_sh[LAST] & ~we_prev & ~ce_sh[LAST];
    assign rd_start = ~oe_sh[LAST] & oe_prev & ~ce_sh[LAST];
    assign wr_addr  = a_sh[LAST];
    assign wr_data  = d_sh[LAST];

endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
    import fcmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [CMD_ADDR_W-1:0] wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  seq_ok,
    input  logic                  seq_failed,
    output dec_state_t            state,
    output rd_mode_t              rd_mode,
    output logic                  erase_start,
    output logic                  abort
);

    dec_state_t state_n;
    logic       key_a;
    logic       key_b;
    logic       start_d;

    assign key_a = (wr_addr == ADDR_KEY_A) && (wr_data == BYTE_KEY_A);
    assign key_b = (wr_addr == ADDR_KEY_B) && (wr_data == BYTE_KEY_B);

    function automatic logic cmd_at_a(input logic [CMD_ADDR_W-1:0] a,
                                      input logic [7:0] d,
                                      input logic [7:0] code);
        return (a == ADDR_KEY_A) && (d == code);
    endfunction

    assign abort = wr_stb && (state == DS_ERASE) && seq_failed &&
                   (wr_data == BYTE_RESET);

    always_comb begin
        state_n = state;
        unique case (state)
            DS_READ, DS_IDENT: begin
                if (wr_stb) state_n = key_a ? DS_UNLK1 : DS_READ;
            end
            DS_UNLK1: begin
                if (wr_stb) state_n = key_b ? DS_UNLK2 : DS_READ;
            end
            DS_UNLK2: begin
                if (wr_stb) begin
                    if (cmd_at_a(wr_addr, wr_data, BYTE_IDENT))
                        state_n = DS_IDENT;
                    else if (cmd_at_a(wr_addr, wr_data, BYTE_ERS_SETUP))
                        state_n = DS_ERS_SETUP;
                    else
                        state_n = DS_READ;
                end
            end
            DS_ERS_SETUP: begin
                if (wr_stb) state_n = key_a ? DS_ERS_UNLK1 : DS_READ;
            end
            DS_ERS_UNLK1: begin
                if (wr_stb) state_n = key_b ? DS_ERS_UNLK2 : DS_READ;
            end
            DS_ERS_UNLK2: begin
                if (wr_stb)
                    state_n = cmd_at_a(wr_addr, wr_data, BYTE_CHIP_ERASE) ?
                              DS_ERASE : DS_READ;
            end
            DS_ERASE: begin
                if (seq_ok || abort) state_n = DS_READ;
            end
        endcase
    end

    assign start_d = wr_stb && (state == DS_ERS_UNLK2) &&
                     cmd_at_a(wr_addr, wr_data, BYTE_CHIP_ERASE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= DS_READ;
            erase_start <= 1'b0;
        end else begin
            state       <= state_n;
            erase_start <= start_d;
        end
    end

    always_comb begin
        unique case (state)
            DS_IDENT: rd_mode = RD_IDENT;
            DS_ERASE: rd_mode = RD_STATUS;
            default:  rd_mode = RD_ARRAY;
        endcase
    end

endmodule

// File: rtl/fcmd_erase_seq.sv
module fcmd_erase_seq
    import fcmd_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       done,
    input  logic       abort,
    input  logic       rd_start,
    output seq_state_t state,
    output logic       seq_ok,
    output logic       seq_failed,
    output logic [7:0] status
);

    localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    seq_state_t     state_n;
    logic [CNT_W-1:0] cnt;
    logic           toggle;

    always_comb begin
        state_n = state;
        unique case (state)
            SQ_IDLE: if (start) state_n = SQ_RUN;
            SQ_RUN: begin
                if (done)                 state_n = SQ_IDLE;
                else if (cnt == CNT_LAST) state_n = SQ_FAIL;
            end
            SQ_FAIL: if (abort) state_n = SQ_IDLE;
            default: state_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            cnt    <= '0;
            toggle <= 1'b0;
        end else begin
            state <= state_n;
            if (state == SQ_RUN) cnt <= cnt + 1'b1;
            else                 cnt <= '0;
            if (rd_start && (state != SQ_IDLE)) toggle <= ~toggle;
        end
    end

    assign seq_ok     = (state == SQ_RUN) && done;
    assign seq_failed = (state == SQ_FAIL);
    assign status     = {1'b0, toggle, seq_failed, 5'b0_0000};

endmodule

// File: rtl/fcmd_read_mux.sv
module fcmd_read_mux
    import fcmd_pkg::*;
#(
    parameter bit BOOT_TOP = 1'b1
) (
    input  rd_mode_t   rd_mode,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic [1:0] sel,
    input  logic [7:0] array_rdata,
    input  logic       sect_prot,
    input  logic [7:0] status,
    output logic [7:0] dout
);

    logic [7:0] dev_code;
    logic [7:0] id_byte;
    logic [7:0] value;

    generate
        if (BOOT_TOP) begin : g_top
            assign dev_code = CODE_DEV_TOP;
        end else begin : g_bottom
            assign dev_code = CODE_DEV_BOTTOM;
        end
    endgenerate

    always_comb begin
        unique case (sel)
            2'b00: id_byte = CODE_MAKER;
            2'b01: id_byte = dev_code;
            2'b10: id_byte = {7'b000_0000, sect_prot};
            2'b11: id_byte = 8'h00;
        endcase
    end

    always_comb begin
        unique case (rd_mode)
            RD_IDENT:  value = id_byte;
            RD_STATUS: value = status;
            default:   value = array_rdata;
        endcase
    end

    assign dout = (!ce_n && !oe_n) ? value : 8'h00;

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import fcmd_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int ERASE_TIMEOUT = 64,
    parameter bit BOOT_TOP      = 1'b1,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_din,
    output logic [7:0]        bus_dout,
    output logic [ADDR_W-1:0] array_addr,
    input  logic [7:0]        array_rdata,
    input  logic              sect_prot,
    output logic              erase_start,
    input  logic              erase_done
);

    logic                  wr_stb;
    logic [CMD_ADDR_W-1:0] wr_addr;
    logic [7:0]            wr_data;
    logic                  rd_start;
    dec_state_t            dec_state;
    seq_state_t            seq_state;
    rd_mode_t              rd_mode;
    logic                  abort_pulse;
    logic                  seq_ok;
    logic                  seq_failed;
    logic [7:0]            status;

    assign array_addr = bus_addr;

    fcmd_bus_sync #(
        .STAGES (SYNC_STAGES),
        .AW     (CMD_ADDR_W)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (bus_ce_n),
        .we_n     (bus_we_n),
        .oe_n     (bus_oe_n),
        .addr     (bus_addr[CMD_ADDR_W-1:0]),
        .din      (bus_din),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_start (rd_start)
    );

    fcmd_decoder u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .seq_ok      (seq_ok),
        .seq_failed  (seq_failed),
        .state       (dec_state),
        .rd_mode     (rd_mode),
        .erase_start (erase_start),
        .abort       (abort_pulse)
    );

    fcmd_erase_seq #(
        .TIMEOUT (ERASE_TIMEOUT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (erase_start),
        .done       (erase_done),
        .abort      (abort_pulse),
        .rd_start   (rd_start),
        .state      (seq_state),
        .seq_ok     (seq_ok),
        .seq_failed (seq_failed),
        .status     (status)
    );

    fcmd_read_mux #(
        .BOOT_TOP (BOOT_TOP)
    ) u_mux (
        .rd_mode     (rd_mode),
        .ce_n        (bus_ce_n),
        .oe_n        (bus_oe_n),
        .sel         (bus_addr[1:0]),
        .array_rdata (array_rdata),
        .sect_prot   (sect_prot),
        .status      (status),
        .dout        (bus_dout)
    );

endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk
    import fcmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_ce_n,
    input logic       bus_oe_n,
    input logic [7:0] bus_dout,
    input logic [7:0] array_rdata,
    input logic       erase_start,
    input logic       wr_stb,
    input logic       abort_pulse,
    input dec_state_t dec_state,
    input seq_state_t seq_state
);

    logic reading;
    assign reading = !bus_ce_n && !bus_oe_n;

    assert_array_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_state == DS_READ && reading) |-> (bus_dout == array_rdata));

    assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    assert_start_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> (seq_state == SQ_RUN));

    assert_run_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_RUN && reading) |-> (!bus_dout[7] && !bus_dout[5]));

    assert_fail_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_FAIL && reading) |-> (bus_dout[5] && !bus_dout[7]));

    assert_fail_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_FAIL && !abort_pulse) |=> (seq_state == SQ_FAIL));

    assert_no_write_no_move_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb && dec_state != DS_ERASE) |=> $stable(dec_state));

endmodule

bind flash_cmd_if flash_cmd_if_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_ce_n    (bus_ce_n),
    .bus_oe_n    (bus_oe_n),
    .bus_dout    (bus_dout),
    .array_rdata (array_rdata),
    .erase_start (erase_start),
    .wr_stb      (wr_stb),
    .abort_pulse (abort_pulse),
    .dec_state   (dec_state),
    .seq_state   (seq_state)
);

// File: tb/flash_cmd_if_test.sv
`timescale 1ns/1ps
module flash_cmd_if_test;

    localparam int AW = 18;
    localparam int TO = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout, dout_b, rdata;
    logic [AW-1:0] aaddr, aaddr_b;
    logic          prot, start, start_b;
    logic          done = 1'b0;

    int checks = 0, errors = 0;
    int cyc = 0, target = -1, done_delay = -1, start_cnt = 0;
    logic [7:0] v, v2;
    logic [7:0] vb;

    always #10 clk = ~clk;

    function automatic logic [7:0] arr_f(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign rdata = arr_f(aaddr);
    assign prot  = aaddr[16] ^ aaddr[17];

    flash_cmd_if #(.ADDR_W(AW), .ERASE_TIMEOUT(TO), .BOOT_TOP(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr(addr), .bus_din(din), .bus_dout(dout), .array_addr(aaddr),
        .array_rdata(rdata), .sect_prot(prot), .erase_start(start), .erase_done(done));

    flash_cmd_if #(.ADDR_W(AW), .ERASE_TIMEOUT(TO), .BOOT_TOP(1'b0)) uut_bot (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr(addr), .bus_din(din), .bus_dout(dout_b), .array_addr(aaddr_b),
        .array_rdata(arr_f(aaddr_b)), .sect_prot(aaddr_b[16] ^ aaddr_b[17]),
        .erase_start(start_b), .erase_done(done));

    // completion driver timed from the observed request pulse
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (start) begin
            start_cnt = start_cnt + 1;
            target = (done_delay >= 0) ? cyc + done_delay : -1;
        end
        done = (target >= 0) && (cyc == target);
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d, input logic use_ce);
        @(negedge clk);
        addr = a; din = d; ce_n = ~use_ce;
        @(negedge clk); we_n = 1'b0;
        wait_n(2);      we_n = 1'b1;
        wait_n(4);      ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] r, output logic [7:0] rb);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        wait_n(4);
        r = dout; rb = dout_b;
        oe_n = 1'b1; ce_n = 1'b1;
        wait_n(2);
    endtask

    task automatic unlock();
        bus_wr(18'h00555, 8'hAA, 1'b1);
        bus_wr(18'h002AA, 8'h55, 1'b1);
    endtask

    task automatic erase_cmd();
        unlock();
        bus_wr(18'h00555, 8'h80, 1'b1);
        unlock();
        bus_wr(18'h00555, 8'h10, 1'b1);
    endtask

    logic finished = 1'b0;

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        int sc;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);

        // R1: reset state
        chk("R1 start low", {7'b0, start}, 8'h00);
        bus_rd(18'h01234, v, vb);
        chk("R1 read after reset", v, arr_f(18'h01234));

        // R2: array reads over an address sweep, idle output
        for (int i = 0; i < 16; i++) begin
            a = AW'(i * 16'h1357 + 3);
            bus_rd(a, v, vb);
            chk("R2 array", v, arr_f(a));
        end
        chk("R2 idle bus", dout, 8'h00);

        // R12: full identification sequence with chip enable high
        bus_wr(18'h00555, 8'hAA, 1'b0);
        bus_wr(18'h002AA, 8'h55, 1'b0);
        bus_wr(18'h00555, 8'h90, 1'b0);
        bus_rd(18'h00100, v, vb);
        chk("R12 ce high ignored", v, arr_f(18'h00100));

        // R3 R4 R5: identification sweep over selector and sectors
        unlock();
        bus_wr(18'h00555, 8'h90, 1'b1);
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 4; k++) begin
                a = {s[1:0], 14'(s * 37 + 5), k[1:0]};
                bus_rd(a, v, vb);
                case (k)
                    0: begin chk("R3 maker", v, 8'hC2); chk("R3 maker bottom", vb, 8'hC2); end
                    1: begin chk("R4 device top", v, 8'hB0); chk("R4 device bottom", vb, 8'h34); end
                    2: chk("R5 protection", v, {7'b0, a[16] ^ a[17]});
                    default: chk("R4 reserved", v, 8'h00);
                endcase
            end
        end

        // R6: reset byte back to array, stray command stays there
        bus_wr(18'h00000, 8'hF0, 1'b1);
        bus_rd(18'h00000, v, vb);
        chk("R6 after reset byte", v, arr_f(18'h00000));
        bus_wr(18'h00555, 8'h90, 1'b1);
        bus_rd(18'h00000, v, vb);
        chk("R6 lone command", v, arr_f(18'h00000));

        // R7: broken sequences at several steps
        unlock();
        bus_wr(18'h00555, 8'h42, 1'b1);
        bus_wr(18'h00555, 8'h90, 1'b1);
        bus_rd(18'h00000, v, vb);
        chk("R7 bad third byte", v, arr_f(18'h00000));
        bus_wr(18'h00555, 8'hAA, 1'b1);
        bus_wr(18'h002AB, 8'h55, 1'b1);
        bus_wr(18'h00555, 8'h90, 1'b1);
        bus_rd(18'h00000, v, vb);
        chk("R7 bad second address", v, arr_f(18'h00000));
        sc = start_cnt;
        unlock();
        bus_wr(18'h00555, 8'h80, 1'b1);
        bus_wr(18'h00555, 8'hAA, 1'b1);
        bus_wr(18'h002AA, 8'h77, 1'b1);
        bus_wr(18'h00555, 8'h10, 1'b1);
        wait_n(4);
        chk("R7 broken erase no request", 8'(start_cnt - sc), 8'h00);

        // R8 R9 R10: erase finishing on the last budget edge
        done_delay = TO;
        sc = start_cnt;
        erase_cmd();
        wait_n(2);
        chk("R8 one request pulse", 8'(start_cnt - sc), 8'h01);
        bus_rd(18'h00040, v, vb);
        bus_rd(18'h00040, v2, vb);
        chk("R9 busy polarity", v & 8'hA0, 8'h00);
        chk("R9 toggle", (v ^ v2) & 8'h40, 8'h40);
        bus_wr(18'h00000, 8'hF0, 1'b1);
        bus_rd(18'h00040, v, vb);
        chk("R9 reset byte ignored while running", v & 8'hA0, 8'h00);
        wait_n(TO);
        bus_rd(18'h00040, v, vb);
        chk("R10 done on last edge", v, arr_f(18'h00040));

        // R10: early completion
        done_delay = 5;
        erase_cmd();
        wait_n(10);
        bus_rd(18'h00777, v, vb);
        chk("R10 early done", v, arr_f(18'h00777));

        // R11: completion one edge late, then abort
        done_delay = TO + 1;
        erase_cmd();
        wait_n(TO + 8);
        bus_rd(18'h00010, v, vb);
        chk("R11 failed status", v & 8'hA0, 8'h20);
        unlock();
        bus_rd(18'h00010, v, vb);
        chk("R11 other writes ignored", v & 8'hA0, 8'h20);
        bus_wr(18'h00000, 8'hF0, 1'b1);
        bus_rd(18'h00010, v, vb);
        chk("R11 abort to array", v, arr_f(18'h00010));

        // R11: no completion at all
        done_delay = -1;
        erase_cmd();
        wait_n(TO + 8);
        bus_rd(18'h00020, v, vb);
        chk("R11 timeout status", v & 8'hA0, 8'h20);
        bus_wr(18'h00000, 8'hF0, 1'b1);
        bus_rd(18'h00020, v, vb);
        chk("R11 abort again", v, arr_f(18'h00020));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule